// File: doc/BRIEF.md
# Device Status Register with Sticky Change Flags

This block holds the one-byte status word that a local microcontroller uses to follow the state of the device side of a USB port. Two bits are ordinary read/write controls: whether the device presents itself as connected, and whether it is suspended. Three bits are sticky event flags. They record a connect change, a suspend change and a received bus reset, and each one stays set until the microcontroller reads the word.

The microcontroller addresses the word with command code 0xFE. A read strobe with that code captures the word into the read-data register and clears the three event flags. A write strobe with that code loads only the two writable bits. Pulses from the USB core set the flags and move the suspend bit. Each set flag is mirrored on an interrupt-flag output, and the interrupt request is the OR of those flags.

A bus reset also produces a one-cycle request that returns the device to its default state: unconfigured and answering on address 0.

Top module: `devstat_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data, int_flags, irq, conn_en and go_default are all 0.
- R2: A read strobe with cmd_code 0xFE loads rd_data at that clock edge with the status word as it was before the edge: bit 0 connect, bit 1 connect-change flag, bit 2 suspend, bit 3 suspend-change flag, bit 4 bus-reset flag, bits 7..5 zero. rd_data holds its value until the next such read.
- R3: A write strobe with cmd_code 0xFE loads connect from wr_data[0] and suspend from wr_data[2]. The other data bits are ignored, so a write neither sets nor clears any flag.
- R4: ev_bus_reset sets the bus-reset flag (bit 4) and raises go_default for exactly the following cycle.
- R5: ev_suspend sets the suspend bit and ev_resume clears it. Either pulse sets the suspend-change flag (bit 3). When both arrive in the same cycle, resume wins and suspend ends at 0.
- R6: ev_conn_chg sets the connect-change flag (bit 1).
- R7: A read with cmd_code 0xFE clears bits 1, 3 and 4 after the read. Bits 0 and 2 are unchanged.
- R8: When an event arrives in the same cycle as a clearing read, its flag stays set after the read. The read data shows the flag's value from before that event.
- R9: int_flags is {bus-reset, suspend-change, connect-change} (bits 2..0), and irq is 1 exactly when any of them is 1. irq falls only after a read that clears the last set flag.
- R10: Read and write strobes with any cmd_code other than 0xFE have no effect.
- R11: When a suspend or resume event arrives in the same cycle as a write, the event decides the suspend bit. The connect bit still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 8 | Command code presented with a strobe |
| rd_stb | input | 1 | Read strobe, one cycle |
| wr_stb | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_suspend | input | 1 | Suspend entry pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_conn_chg | input | 1 | Connect change pulse |
| rd_data | output | 8 | Captured status word |
| int_flags | output | 3 | Interrupt register bits {bus reset, suspend change, connect change} |
| irq | output | 1 | Interrupt request to the microcontroller |
| conn_en | output | 1 | Connect control |
| go_default | output | 1 | One-cycle request to return to the default state |

## Verification
Two functions can land in the same cycle: a clearing read of the status word and a core event that sets one of the flags being cleared. A second collision of the same kind is a software write of the suspend bit in the same cycle as a suspend or resume pulse. Directed steps line these up on one clock edge. The random phase also produces them often, because it mixes sparse event pulses with frequent reads and writes. Each collision is judged by comparing the captured read data, the flags left behind and the interrupt line against a bench model built from the requirements: the read must show the pre-edge word, the flag must survive, and the event must decide the suspend bit.

// File: rtl/devstat_pkg.sv
// Package: shared widths, bit positions and write mask of the device status word.
// Assumes an 8-bit status word; the flag ordering inside the interrupt vector is fixed here.
package devstat_pkg;
    localparam int STAT_W       = 8;
    localparam int NUM_EVT      = 3;
    // status word bit positions (decoded by the microcontroller)
    localparam int BIT_CONN     = 0;
    localparam int BIT_CONN_CHG = 1;
    localparam int BIT_SUSP     = 2;
    localparam int BIT_SUSP_CHG = 3;
    localparam int BIT_BUS_RST  = 4;
    // index of each event inside the flag / interrupt vector
    localparam int EVT_CONN     = 0;
    localparam int EVT_SUSP     = 1;
    localparam int EVT_RST      = 2;
    // software-writable bits of the status word
    localparam logic [STAT_W-1:0] RW_MASK = STAT_W'((1 << BIT_CONN) | (1 << BIT_SUSP));
endpackage

// File: rtl/devstat_flags.sv
// Module: bank of sticky event flags that clear on read.
// Assumes set_i carries one-cycle pulses. clr_i is the read strobe; a set in the same
// cycle wins over the clear, so no event is lost.
module devstat_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // sticky flag: set has priority over clear-on-read
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i)
                q_o[i] <= 1'b0;
        end

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
        assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !q_o[i]);
    end
endmodule

// File: rtl/devstat_state.sv
// Module: writable status bits (connect, suspend) and the default-state request.
// Assumes wr_hit is already qualified by the command code. Suspend and resume events
// override a software write of the suspend bit, and resume overrides suspend entry.
module devstat_state
    import devstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              susp_enter,
    input  logic              resume,
    input  logic              bus_rst,
    output logic [STAT_W-1:0] rw_o,
    output logic              go_default_o
);
    logic [STAT_W-1:0] rw_next;

    // next value: masked software write, then core events on the suspend bit
    always_comb begin
        rw_next = rw_o;
        if (wr_hit)
            rw_next = (rw_o & ~RW_MASK) | (wr_data & RW_MASK);
        if (resume)
            rw_next[BIT_SUSP] = 1'b0;
        else if (susp_enter)
            rw_next[BIT_SUSP] = 1'b1;
    end

    // state register for the writable bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            rw_o <= '0;
        else
            rw_o <= rw_next;
    end

    // one-cycle default-state request following a bus reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            go_default_o <= 1'b0;
        else
            go_default_o <= bus_rst;
    end

    assert_resume_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !rw_o[BIT_SUSP]);
    assert_suspend_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_enter && !resume) |=> rw_o[BIT_SUSP]);
    assert_write_conn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (rw_o[BIT_CONN] == $past(wr_data[BIT_CONN])));
endmodule

// File: rtl/devstat_irq.sv
// Module: interrupt register view and request line.
// Assumes flags_i comes from registered sticky flags; the request is their OR, so it
// tracks the flags in the same cycle with no added latency.
module devstat_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic         rd_hit,
    output logic [N-1:0] int_o,
    output logic         irq_o
);
    // interrupt register bits mirror the set flags; request is any of them
    always_comb begin
        int_o = flags_i;
        irq_o = |flags_i;
    end

    assert_irq_falls_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(rd_hit));
endmodule

// File: rtl/devstat_reg.sv
// Module: top of the device status register. Decodes the command code, assembles the
// status word, captures it on a read and wires events into flags and state.
// Assumes strobes and events are single-cycle pulses synchronous to clk.
module devstat_reg
    import devstat_pkg::*;
#(
    parameter logic [7:0] CMD_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cmd_code,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              ev_bus_reset,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              ev_conn_chg,
    output logic [STAT_W-1:0] rd_data,
    output logic [NUM_EVT-1:0] int_flags,
    output logic              irq,
    output logic              conn_en,
    output logic              go_default
);
    logic                rd_hit, wr_hit;
    logic [NUM_EVT-1:0]  evt_set, flags;
    logic [STAT_W-1:0]   rw_bits, status;

    // command decode
    always_comb begin
        rd_hit = rd_stb && (cmd_code == CMD_CODE);
        wr_hit = wr_stb && (cmd_code == CMD_CODE);
    end

    // route core events into the flag vector
    always_comb begin
        evt_set           = '0;
        evt_set[EVT_CONN] = ev_conn_chg;
        evt_set[EVT_SUSP] = ev_suspend | ev_resume;
        evt_set[EVT_RST]  = ev_bus_reset;
    end

    devstat_flags #(.N(NUM_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (rd_hit),
        .q_o   (flags)
    );

    devstat_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (wr_hit),
        .wr_data      (wr_data),
        .susp_enter   (ev_suspend),
        .resume       (ev_resume),
        .bus_rst      (ev_bus_reset),
        .rw_o         (rw_bits),
        .go_default_o (go_default)
    );

    devstat_irq #(.N(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .rd_hit  (rd_hit),
        .int_o   (int_flags),
        .irq_o   (irq)
    );

    // assemble the status word from writable bits and flags
    always_comb begin
        status               = rw_bits & RW_MASK;
        status[BIT_CONN_CHG] = flags[EVT_CONN];
        status[BIT_SUSP_CHG] = flags[EVT_SUSP];
        status[BIT_BUS_RST]  = flags[EVT_RST];
    end

    // capture register for the microcontroller read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_hit)
            rd_data <= status;
    end

    assign conn_en = rw_bits[BIT_CONN];

    assert_default_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_default |-> $past(ev_bus_reset));
    assert_rd_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(rd_data));
endmodule

// File: tb/sim_devstat_reg.sv
module sim_devstat_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cmd_code, wr_data, rd_data;
    logic       rd_stb, wr_stb, ev_bus_reset, ev_suspend, ev_resume, ev_conn_chg;
    logic [2:0] int_flags;
    logic       irq, conn_en, go_default;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    logic       m_conn, m_susp, m_cc, m_sc, m_br, m_def;
    logic [7:0] m_rd;

    always #10 clk = ~clk;

    devstat_reg u0 (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend),
        .ev_resume(ev_resume), .ev_conn_chg(ev_conn_chg), .rd_data(rd_data),
        .int_flags(int_flags), .irq(irq), .conn_en(conn_en), .go_default(go_default)
    );

    function automatic logic [7:0] m_status();
        return {3'b000, m_br, m_sc, m_susp, m_cc, m_conn};
    endfunction

    function automatic logic [13:0] m_outputs();
        return {m_rd, m_br | m_sc | m_cc, m_br, m_sc, m_cc, m_conn, m_def};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, advance the model, compare at the next falling edge
    task automatic step(logic br, logic se, logic rs, logic cc, logic rd, logic wr,
                        logic [7:0] code, logic [7:0] wd, string tag);
        logic rdh, wrh;
        ev_bus_reset = br; ev_suspend = se; ev_resume = rs; ev_conn_chg = cc;
        rd_stb = rd; wr_stb = wr; cmd_code = code; wr_data = wd;
        rdh = rd && (code == 8'hFE);
        wrh = wr && (code == 8'hFE);
        @(posedge clk);
        if (rdh) m_rd = m_status();
        m_cc   = cc | (m_cc & ~rdh);
        m_sc   = (se | rs) | (m_sc & ~rdh);
        m_br   = br | (m_br & ~rdh);
        if (wrh) m_conn = wd[0];
        if (rs) m_susp = 1'b0;
        else if (se) m_susp = 1'b1;
        else if (wrh) m_susp = wd[2];
        m_def = br;
        @(negedge clk);
        chk(tag, 32'({rd_data, irq, int_flags, conn_en, go_default}), 32'(m_outputs()));
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 8'h00, 8'h00, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        ev_bus_reset = 0; ev_suspend = 0; ev_resume = 0; ev_conn_chg = 0;
        rd_stb = 0; wr_stb = 0; cmd_code = 8'hFE; wr_data = 8'hFF;
        m_conn = 0; m_susp = 0; m_cc = 0; m_sc = 0; m_br = 0; m_def = 0; m_rd = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 32'({rd_data, irq, int_flags, conn_en, go_default}), 32'd0);
        rst_n = 1'b1;
        idle("R1 idle after reset");

        step(0, 0, 0, 0, 0, 1, 8'hFE, 8'hFF, "R3 write all ones");
        step(0, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R2 R3 read masked word");
        chk("R3 read value", 32'(rd_data), 32'h05);
        step(0, 0, 0, 0, 0, 1, 8'h12, 8'h00, "R10 write wrong code");
        step(0, 0, 0, 0, 1, 0, 8'h7E, 8'h00, "R10 read wrong code");
        step(0, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R10 state kept");
        step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R6 connect change");
        step(0, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R6 R7 read flag");
        chk("R6 flag seen", 32'(rd_data), 32'h07);
        step(0, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R7 flag cleared");
        step(0, 0, 1, 0, 0, 0, 8'h00, 8'h00, "R5 resume");
        step(0, 1, 1, 0, 1, 0, 8'hFE, 8'h00, "R5 R8 both events with read");
        step(0, 1, 0, 0, 0, 1, 8'hFE, 8'h01, "R11 suspend beats write");
        step(0, 0, 1, 0, 0, 1, 8'hFE, 8'h04, "R11 resume beats write");
        step(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R4 bus reset");
        idle("R4 default pulse ends");
        step(1, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R8 bus reset during read");
        step(0, 0, 0, 0, 1, 0, 8'hFE, 8'h00, "R9 read clears all");
        idle("R9 irq low");

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] code;
            code = ($urandom_range(3) != 0) ? 8'hFE : 8'($urandom);
            step($urandom_range(15) == 0, $urandom_range(11) == 0, $urandom_range(11) == 0,
                 $urandom_range(9) == 0, $urandom_range(2) == 0, $urandom_range(3) == 0,
                 code, 8'($urandom), "R2 R7 R8 R9 R11 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule